// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate synchronous SRAM with a small internal array and a single shared command bus. Every clock it accepts one command (load a read, load a write, deselect, or continue the current burst) together with an address and four active-low byte write enables. Read data leaves the block two cycles after its command. The data for a write enters two cycles after its command. Because both directions have the same latency, reads and writes can follow each other in any order with no idle cycle on the data bus.

The data port is modelled as separate input, output and drive-enable signals. The drive enable is active only in cycles that carry read data, and only while the asynchronous output enable is low. A clock-enable stall freezes the whole pipeline. Three chip-select inputs deselect the device without cancelling accesses that are already in flight. A read that targets a word whose write is still in the pipeline returns the newer bytes.

Top module: `zt_sram`

## Requirements
- R1: A write command (load_n=0, rd_wrn=0, selected) registers its address and byte enables on one rising edge. The word on dq_in at the second rising edge after that is written into the array, on the lanes whose enable is low.
- R2: For a read command registered on edge E, dq_out carries the addressed word and dq_oe is high (with oe_n low) from edge E+2 until edge E+3.
- R3: Reads and writes may alternate on consecutive cycles with no gap. A read always returns the newest data, including bytes from a write issued one or two commands before it.
- R4: With load_n=1 the address, chip selects and rd_wrn are ignored. The burst keeps the direction of its load and steps a 2-bit counter. The low two address bits are start XOR count when burst_xor=1 and start+count (mod 4) when burst_xor=0. The sequence wraps after four accesses.
- R5: While hold=1 no state changes and no array write happens. dq_oe keeps its value, so the port stays driven during a read and undriven during a write.
- R6: The device is deselected when sel_a_n=1, sel_b=0 or sel_c_n=1 during a load. Reads and writes already in flight still complete, and the port is then undriven. A continue cycle after a deselect stays deselected.
- R7: be_n[i]=0 enables lane i, which is dq bits [i*LANE_W +: LANE_W]. A write with all four be_n bits high changes no array word.
- R8: dq_oe is low whenever oe_n is high, and it is low in every write-data cycle whatever the value of oe_n.
- R9: A synchronous active-high rst empties the pipeline, ends any burst and turns off the port. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Stall: 1 inhibits the cycle |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads a new access, 1 continues the burst |
| rd_wrn | input | 1 | 1 read, 0 write (at load) |
| be_n | input | LANES | Byte write enables, active low |
| addr | input | log2(WORDS) | Word address |
| burst_xor | input | 1 | 1 interleaved (XOR) order, 0 linear order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Drive enable of the data port |

## Verification
The bench targets a read issued one cycle after a write to the same word, where the new bytes must be merged into the read. A design without that merge returns the stale word there. Stalls are placed in the middle of read and write pipelines. A design that lets stage registers or the port state move during a stall shifts the data by a cycle, or commits the write with the wrong dq_in. Bursts are run in both orders, past the wrap point and with junk on the address and select pins, which exposes counters that reload, order functions that are swapped, and continue cycles that see the pins. Deselects on each of the three select pins, all-high byte-enable writes, oe_n pulses and a reset in the middle of traffic check that deselects drain the pipeline, aborts leave the array alone, the port gating holds, and the array survives reset.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       xor_mode);
    logic [1:0] r;
    if (xor_mode) r = start ^ beat;
    else          r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
  import zt_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hold,
  input  logic                       sel_a_n,
  input  logic                       sel_b,
  input  logic                       sel_c_n,
  input  logic                       load_n,
  input  logic                       rd_wrn,
  input  logic [LANES-1:0]           be_n,
  input  logic [$clog2(WORDS)-1:0]   addr,
  input  logic                       burst_xor,
  output op_e                        cmd_op,
  output logic [$clog2(WORDS)-1:0]   cmd_addr,
  output logic [LANES-1:0]           cmd_be_n
);
  localparam int ADDR_W = $clog2(WORDS);

  op_e               burst_op;
  logic [ADDR_W-1:0] base;
  logic [1:0]        beat;
  logic [1:0]        beat_nxt;
  logic              desel;

  assign desel    = sel_a_n | ~sel_b | sel_c_n;
  assign beat_nxt = beat + 2'd1;
  assign cmd_be_n = be_n;

  always_comb begin
    if (!load_n) begin
      cmd_op   = desel ? OP_NONE : (rd_wrn ? OP_RD : OP_WR);
      cmd_addr = addr;
    end else begin
      cmd_op   = burst_op;
      cmd_addr = {base[ADDR_W-1:2], burst_low(base[1:0], beat_nxt, burst_xor)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_op <= OP_NONE;
      base     <= '0;
      beat     <= '0;
    end else if (!hold) begin
      if (!load_n) begin
        burst_op <= cmd_op;
        base     <= addr;
        beat     <= '0;
      end else begin
        beat     <= beat_nxt;
      end
    end
  end

  // R6: a continue right after a deselect issues nothing
  a_r6_desel_sticks: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load_n && desel) |=> (!load_n || cmd_op == OP_NONE));

endmodule

// File: rtl/zt_data_path.sv
module zt_data_path
  import zt_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  op_e                         s1_op,
  input  logic [$clog2(WORDS)-1:0]    s1_addr,
  input  op_e                         s2_op,
  input  logic [$clog2(WORDS)-1:0]    s2_addr,
  input  logic [LANES-1:0]            s2_be_n,
  input  logic [LANES*LANE_W-1:0]     din,
  output logic [LANES*LANE_W-1:0]     q,
  output logic                        q_valid
);
  localparam int DATA_W = LANES * LANE_W;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en_n);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (!en_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_hold;
  logic              commit_we;
  logic              fwd_hit;

  // internal events named for the checks
  assign commit_we = !hold && (s2_op == OP_WR) && (s2_be_n != '1);
  assign fwd_hit   = (s2_op == OP_WR) && (s1_op == OP_RD) && (s1_addr == s2_addr);

  always_ff @(posedge clk) begin
    if (commit_we) mem[s2_addr] <= lane_merge(mem[s2_addr], din, s2_be_n);
  end

  // array read one stage early, bypassing the write that commits on the same edge
  always_ff @(posedge clk) begin
    if (!hold && s1_op == OP_RD)
      rd_hold <= fwd_hit ? lane_merge(mem[s1_addr], din, s2_be_n) : mem[s1_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
    end else if (!hold) begin
      q_valid <= (s2_op == OP_RD);
      if (s2_op == OP_RD) q <= rd_hold;
    end
  end

  // R3: a bypassed read takes the enabled lanes from the write data
  a_r3_bypass_lane0: assert property (@(posedge clk) disable iff (rst)
    (!hold && fwd_hit && !s2_be_n[0]) |=> (rd_hold[LANE_W-1:0] == $past(din[LANE_W-1:0])));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic                        sel_a_n,
  input  logic                        sel_b,
  input  logic                        sel_c_n,
  input  logic                        load_n,
  input  logic                        rd_wrn,
  input  logic [LANES-1:0]            be_n,
  input  logic [$clog2(WORDS)-1:0]    addr,
  input  logic                        burst_xor,
  input  logic                        oe_n,
  input  logic [LANES*LANE_W-1:0]     dq_in,
  output logic [LANES*LANE_W-1:0]     dq_out,
  output logic                        dq_oe
);
  localparam int ADDR_W = $clog2(WORDS);
  localparam int DATA_W = LANES * LANE_W;

  op_e               c_op, s1_op, s2_op;
  logic [ADDR_W-1:0] c_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  c_be_n, s1_be_n, s2_be_n;
  logic [DATA_W-1:0] q;
  logic              q_valid;

  zt_cmd_decode #(.WORDS(WORDS), .LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .hold(hold),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .load_n(load_n), .rd_wrn(rd_wrn), .be_n(be_n), .addr(addr),
    .burst_xor(burst_xor),
    .cmd_op(c_op), .cmd_addr(c_addr), .cmd_be_n(c_be_n)
  );

  // two command stages: stage 2 lines up with the data-bus cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_NONE; s1_addr <= '0; s1_be_n <= '1;
      s2_op <= OP_NONE; s2_addr <= '0; s2_be_n <= '1;
    end else if (!hold) begin
      s1_op <= c_op;  s1_addr <= c_addr;  s1_be_n <= c_be_n;
      s2_op <= s1_op; s2_addr <= s1_addr; s2_be_n <= s1_be_n;
    end
  end

  zt_data_path #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst(rst), .hold(hold),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be_n(s2_be_n),
    .din(dq_in), .q(q), .q_valid(q_valid)
  );

  assign dq_out = q;
  assign dq_oe  = q_valid & ~oe_n;

  // R5: a stall freezes the stages and the port state
  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(s1_op) && $stable(s2_op) && $stable(q_valid) && $stable(dq_out)));

  // R2: a read in stage 2 drives the port in the following cycle
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    (!hold && s2_op == OP_RD) |=> (dq_oe == !oe_n));

  // R8: write-data cycles never drive the port
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (!hold && s2_op == OP_WR) |=> !dq_oe);

  // R8: output enable gates the port
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R9: reset turns the port off
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> !dq_oe);

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;
  localparam int LANES = 4;
  localparam int LW    = 8;
  localparam int AW    = 8;
  localparam int DW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic          hold, sel_a_n, sel_b, sel_c_n, load_n, rd_wrn, burst_xor, oe_n;
  logic [LANES-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .hold(hold),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .load_n(load_n), .rd_wrn(rd_wrn), .be_n(be_n), .addr(addr),
    .burst_xor(burst_xor), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // reference model: pending-access queue and a word array
  typedef struct packed { logic [1:0] op; logic [AW-1:0] a; logic [LANES-1:0] be; } ent_t;
  ent_t          pq[$];
  logic [DW-1:0] mmem [WORDS];
  logic [1:0]    mk;      // 0 none, 1 read, 2 write
  logic [AW-1:0] mbase;
  logic [1:0]    mcnt;
  logic          exp_v;
  logic [DW-1:0] exp_d;
  bit            ready = 0;
  bit            done  = 0;
  int            total = 0;
  int            bad   = 0;
  string         cur_tag = "R9";

  task automatic model_reset();
    ent_t z;
    z = '0;
    pq.delete();
    pq.push_back(z);
    pq.push_back(z);
    mk = 0; mcnt = 0; mbase = '0; exp_v = 0;
  endtask

  task automatic model_update();
    ent_t o, n;
    if (rst) begin
      model_reset();
      return;
    end
    if (hold) return;
    o = pq.pop_front();
    if (o.op == 2) begin
      for (int l = 0; l < LANES; l++)
        if (!o.be[l]) mmem[o.a][l*LW +: LW] = dq_in[l*LW +: LW];
    end
    if (o.op == 1) begin exp_v = 1; exp_d = mmem[o.a]; end
    else exp_v = 0;
    n = '0;
    if (!load_n) begin
      if (sel_a_n || !sel_b || sel_c_n) mk = 0;
      else begin mk = rd_wrn ? 2'd1 : 2'd2; mbase = addr; mcnt = 0; n.a = addr; end
      n.op = mk;
    end else if (mk != 0) begin
      mcnt = mcnt + 2'd1;
      n.op = mk;
      n.a  = {mbase[AW-1:2], burst_xor ? (mbase[1:0] ^ mcnt) : (mbase[1:0] + mcnt)};
    end
    n.be = be_n;
    pq.push_back(n);
  endtask

  task automatic compare();
    logic eo;
    if (!ready) return;
    eo = exp_v && !oe_n;
    total++;
    if (dq_oe !== eo) begin
      bad++;
      $display("FAIL %s dq_oe actual=%b expected=%b at %0t", cur_tag, dq_oe, eo, $time);
    end
    if (eo) begin
      total++;
      if (dq_out !== exp_d) begin
        bad++;
        $display("FAIL %s dq_out actual=%h expected=%h at %0t", cur_tag, dq_out, exp_d, $time);
      end
    end
  endtask

  // cs: 0 selected, 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high
  task automatic step(input string tag, input bit hd, input int cs, input bit ld_n,
                      input bit rd, input logic [3:0] be, input logic [AW-1:0] a,
                      input bit oen, input bit bx);
    @(negedge clk);
    compare();
    cur_tag = tag;
    hold = hd; load_n = ld_n; rd_wrn = rd; be_n = be; addr = a;
    oe_n = oen; burst_xor = bx;
    sel_a_n = (cs == 1); sel_b = (cs != 2); sel_c_n = (cs == 3);
    dq_in = $urandom;
    model_update();
  endtask

  task automatic rd_cmd(input string t, input logic [AW-1:0] a);
    step(t, 0, 0, 0, 1, 4'hF, a, 0, 1);
  endtask
  task automatic wr_cmd(input string t, input logic [AW-1:0] a, input logic [3:0] be);
    step(t, 0, 0, 0, 0, be, a, 0, 1);
  endtask
  task automatic cont(input string t, input bit bx);
    step(t, 0, 1, 1, $urandom_range(0, 1), 4'($urandom), AW'($urandom), 0, bx);
  endtask
  task automatic idle(input string t);
    step(t, 0, 1, 0, 1, 4'hF, '0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; hold = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0; load_n = 0; rd_wrn = 1;
    be_n = '1; addr = '0; burst_xor = 1; oe_n = 0; dq_in = '0;
    model_reset();
    ready = 1;
    // R9: reset state, port off
    repeat (3) idle("R9");
    @(negedge clk); compare(); rst = 0; idle("R9");

    // R1: fill the array with full-word writes
    for (int i = 0; i < WORDS; i++) wr_cmd("R1", AW'(i), 4'h0);
    idle("R1"); idle("R1");

    // R2: back-to-back reads
    for (int i = 0; i < 8; i++) rd_cmd("R2", AW'(i * 7));
    idle("R2"); idle("R2"); idle("R2");

    // R3: alternating write/read on one word, distance 1 and 2, partial lanes
    wr_cmd("R3", 8'h21, 4'h0); rd_cmd("R3", 8'h21);
    wr_cmd("R3", 8'h21, 4'b1010); rd_cmd("R3", 8'h21);
    wr_cmd("R3", 8'h22, 4'b0110); rd_cmd("R3", 8'h30); rd_cmd("R3", 8'h22);
    wr_cmd("R3", 8'h23, 4'b1100); wr_cmd("R3", 8'h23, 4'b0011); rd_cmd("R3", 8'h23);
    rd_cmd("R3", 8'h23); wr_cmd("R3", 8'h23, 4'h0); rd_cmd("R3", 8'h23);
    idle("R3"); idle("R3"); idle("R3");

    // R4: bursts in both orders, past the wrap, junk on ignored pins
    rd_cmd("R4", 8'h46); step("R4", 0, 0, 0, 1, 4'hF, 8'h46, 0, 1);
    for (int i = 0; i < 5; i++) cont("R4", 1);
    step("R4", 0, 0, 0, 1, 4'hF, 8'h53, 0, 0);
    for (int i = 0; i < 5; i++) cont("R4", 0);
    step("R4", 0, 0, 0, 0, 4'h0, 8'h61, 0, 0);
    for (int i = 0; i < 4; i++) cont("R4", 0);
    step("R4", 0, 0, 0, 0, 4'h5, 8'h6E, 0, 1);
    for (int i = 0; i < 4; i++) cont("R4", 1);
    for (int i = 0; i < 4; i++) rd_cmd("R4", AW'(8'h60 + i));
    for (int i = 0; i < 4; i++) rd_cmd("R4", AW'(8'h6C + i));
    idle("R4"); idle("R4"); idle("R4");

    // R5: stalls inside a read stream and a write stream
    rd_cmd("R5", 8'h10); rd_cmd("R5", 8'h11);
    for (int i = 0; i < 3; i++) step("R5", 1, 0, 0, 0, 4'h0, AW'($urandom), 0, 1);
    rd_cmd("R5", 8'h12); idle("R5");
    step("R5", 1, 0, 0, 0, 4'h0, 8'h55, 0, 1);
    wr_cmd("R5", 8'h12, 4'h0); wr_cmd("R5", 8'h13, 4'h0);
    for (int i = 0; i < 3; i++) step("R5", 1, 0, 0, 1, 4'h0, AW'($urandom), 0, 1);
    rd_cmd("R5", 8'h12); rd_cmd("R5", 8'h13); idle("R5"); idle("R5"); idle("R5");

    // R6: deselect on each pin, drain, continue-deselect
    for (int p = 1; p <= 3; p++) begin
      rd_cmd("R6", AW'(p)); wr_cmd("R6", AW'(p + 4), 4'h0);
      step("R6", 0, p, 0, 1, 4'h0, 8'h99, 0, 1);
      cont("R6", 1); cont("R6", 0);
      rd_cmd("R6", AW'(p + 4)); idle("R6"); idle("R6");
    end

    // R7: lane enables and abort
    wr_cmd("R7", 8'h70, 4'b1110); wr_cmd("R7", 8'h71, 4'b0111);
    wr_cmd("R7", 8'h72, 4'hF); rd_cmd("R7", 8'h72); rd_cmd("R7", 8'h70); rd_cmd("R7", 8'h71);
    idle("R7"); idle("R7"); idle("R7");

    // R8: output enable high during read data, low during write data
    rd_cmd("R8", 8'h05); wr_cmd("R8", 8'h06, 4'h0);
    step("R8", 0, 0, 0, 1, 4'hF, 8'h07, 1, 1);
    step("R8", 0, 1, 0, 1, 4'hF, 8'h00, 1, 1);
    step("R8", 0, 1, 0, 1, 4'hF, 8'h00, 0, 1);
    idle("R8"); idle("R8");

    // R9: reset in mid traffic, array kept
    rd_cmd("R9", 8'h21); wr_cmd("R9", 8'h22, 4'h0);
    @(negedge clk); compare(); rst = 1; model_update();
    idle("R9"); idle("R9");
    @(negedge clk); compare(); rst = 0; cont("R9", 1);
    rd_cmd("R9", 8'h21); rd_cmd("R9", 8'h70); idle("R9"); idle("R9"); idle("R9");

    // mixed random traffic over a small address window
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R3", r < 8, ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : 0,
           $urandom_range(0, 9) < 3, $urandom_range(0, 1),
           ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom),
           AW'($urandom_range(0, 15)), $urandom_range(0, 9) == 0, $urandom_range(0, 1));
    end
    idle("R2"); idle("R2"); idle("R2");
    @(negedge clk); compare();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule